// File: doc/BRIEF.md
# Diagnostic Fault Injection Controller

This block sits on the outgoing datapaths of an I/O port and corrupts them on request, so that the error-detection logic further along can be tested. Software programs one 32-bit control word over a single-cycle CSR read/write interface. The word can turn on any mix of the following:
- inversion of the downstream data-bus parity bit;
- one extra valid cycle at the end of downstream mailbox-command packets;
- inversion of chosen ECC check bits on read-return data;
- bad parity on the CSR read data that this block drives;
- bad parity on the CSR address bus. This last one clears itself after the next CSR access.

Every datapath is combinational through the block. With all injection bits clear, each output equals its input in the same cycle. The only added state is the control word and two flops in the valid stretcher. Because the ECC mask works on single check bits, software picks a single-bit error by setting one mask bit and a double-bit error by setting two.

Top module: `fault_inj_ctl`

## Requirements
- R1: After reset every control bit is zero, a read of the control address returns 0x00000000, and every datapath output equals its input.
- R2: Writable bits are at these positions: 19 (stretch enable), 18 (downstream parity flip), 16 (CSR read-data parity flip) and 7:0 (ECC mask). A read returns them at the same positions. Bits 31:20, 17 and 15:8 always read as zero.
- R3: While `rr_valid_i` is 1, `rr_ecc_o` equals `rr_ecc_i` XOR mask, where mask bit n flips check bit n. While `rr_valid_i` is 0, `rr_ecc_o` equals `rr_ecc_i`.
- R4: During read return, the number of check bits that differ equals the number of set mask bits. One set bit gives a single-bit error and two give a double-bit error.
- R5: While bit 18 is set, `dn_par_o` is the inverse of `dn_par_i`. While it is clear, `dn_par_o` equals `dn_par_i`.
- R6: While bit 19 is set, a packet is a run of cycles with `dn_valid_i` high, and its type is taken from `dn_type_i` in the first cycle of the run. When a packet of type 5 (the mailbox code) ends, `dn_valid_o` stays high for exactly one more cycle.
- R7: Packets of any type other than 5 pass with `dn_valid_o` equal to `dn_valid_i`. When bit 19 is clear, all packet types pass this way.
- R8: A write of 1 to bit 17 makes `csr_apar_o` the inverse of `csr_apar_i` from the next cycle on. The inversion still applies during the next CSR access, at any address, and is gone from the cycle after that access.
- R9: `csr_rdata_par_o` is the XOR of the 32 bits of `csr_rdata_o` when bit 16 is clear, and its inverse when bit 16 is set.
- R10: When no injection is active, data, type, parity, valid and ECC outputs equal their inputs in the same cycle, with no register on the path.
- R11: An access to an address other than 0x40 does not change the control word, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req_i | input | 1 | Single-cycle CSR access strobe |
| csr_wr_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | CSR_AW | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_apar_i | input | 1 | CSR address parity in |
| csr_apar_o | output | 1 | CSR address parity out, possibly inverted |
| csr_rdata_o | output | 32 | CSR read data, zero when not reading the control address |
| csr_rdata_par_o | output | 1 | Parity of CSR read data, possibly inverted |
| dn_valid_i | input | 1 | Downstream valid in |
| dn_type_i | input | TYPE_W | Downstream packet type in |
| dn_data_i | input | DATA_W | Downstream data in |
| dn_par_i | input | 1 | Downstream parity in |
| dn_valid_o | output | 1 | Downstream valid out, possibly stretched |
| dn_type_o | output | TYPE_W | Downstream packet type out |
| dn_data_o | output | DATA_W | Downstream data out |
| dn_par_o | output | 1 | Downstream parity out, possibly inverted |
| rr_valid_i | input | 1 | Read-return valid in |
| rr_data_i | input | RR_W | Read-return data in |
| rr_ecc_i | input | ECC_W | Read-return check bits in |
| rr_valid_o | output | 1 | Read-return valid out |
| rr_data_o | output | RR_W | Read-return data out |
| rr_ecc_o | output | ECC_W | Read-return check bits out, possibly flipped |

## Verification
The checker watches these properties on every cycle:
- reserved and write-only bits read as zero;
- the number of flipped check bits matches the number of mask bits, and nothing is flipped outside read return;
- downstream parity differs only while its flip is enabled;
- input valid always reaches the output;
- any extra valid cycle lasts one cycle and follows a packet end while stretching is enabled;
- forced address parity is gone the cycle after an access.

Other behaviour is shown only by the bench scenarios:
- that the stretch picks the mailbox type among all eight codes;
- that every one of the 256 masks lands on the right bit positions;
- the exact CSR readback values and read-data parity;
- that accesses to other addresses leave the word alone but still consume the address-parity force.

// File: rtl/fij_pkg.sv
package fij_pkg;

   localparam int unsigned CSR_DW        = 32;
   localparam int unsigned MASK_W        = 8;
   localparam int unsigned BIT_CSR_DPAR  = 16;
   localparam int unsigned BIT_CSR_APAR  = 17;
   localparam int unsigned BIT_DN_PAR    = 18;
   localparam int unsigned BIT_VSEQ      = 19;

   typedef struct packed {
      logic              vseq;      // stretch valid on mailbox packets
      logic              dn_par;    // invert downstream parity
      logic              csr_apar;  // invert CSR address parity, self-clearing
      logic              csr_dpar;  // invert CSR read-data parity
      logic [MASK_W-1:0] ecc_mask;  // per-check-bit flip mask
   } ctrl_t;

   // Readback image: write-only and reserved positions return zero.
   function automatic logic [CSR_DW-1:0] ctrl_image(input ctrl_t c);
      logic [CSR_DW-1:0] w;
      w                = '0;
      w[MASK_W-1:0]    = c.ecc_mask;
      w[BIT_CSR_DPAR]  = c.csr_dpar;
      w[BIT_DN_PAR]    = c.dn_par;
      w[BIT_VSEQ]      = c.vseq;
      return w;
   endfunction

endpackage

// File: rtl/fij_csr_regs.sv
module fij_csr_regs
   import fij_pkg::*;
#(
   parameter int unsigned CSR_AW   = 8,
   parameter int unsigned REG_ADDR = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [CSR_AW-1:0] addr_i,
   input  logic [CSR_DW-1:0] wdata_i,
   output logic [CSR_DW-1:0] rdata_o,
   output ctrl_t             ctrl_o
);

   localparam logic [CSR_AW-1:0] HIT_ADDR = REG_ADDR[CSR_AW-1:0];

   ctrl_t ctrl_q;
   logic  hit;
   logic  hit_wr;
   logic  hit_rd;
   logic  unused_wbits;

   assign hit    = req_i && (addr_i == HIT_ADDR);
   assign hit_wr = hit && wr_i;
   assign hit_rd = hit && !wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (hit_wr) begin
            ctrl_q.vseq     <= wdata_i[BIT_VSEQ];
            ctrl_q.dn_par   <= wdata_i[BIT_DN_PAR];
            ctrl_q.csr_dpar <= wdata_i[BIT_CSR_DPAR];
            ctrl_q.ecc_mask <= wdata_i[MASK_W-1:0];
         end
         // Any access that saw the forced address parity consumes it.
         if (ctrl_q.csr_apar && req_i) begin
            ctrl_q.csr_apar <= 1'b0;
         end else if (hit_wr) begin
            ctrl_q.csr_apar <= wdata_i[BIT_CSR_APAR];
         end
      end
   end

   assign rdata_o      = hit_rd ? ctrl_image(ctrl_q) : '0;
   assign ctrl_o       = ctrl_q;
   assign unused_wbits = ^{wdata_i[CSR_DW-1:BIT_VSEQ+1], wdata_i[BIT_CSR_DPAR-1:MASK_W]};

endmodule

// File: rtl/fij_flip.sv
module fij_flip #(
   parameter int unsigned W     = 1,
   parameter bit          GATED = 1'b1
) (
   input  logic [W-1:0] in_i,
   input  logic [W-1:0] mask_i,
   input  logic         en_i,
   output logic [W-1:0] out_o
);

   generate
      if (GATED) begin : g_gated
         assign out_o = en_i ? (in_i ^ mask_i) : in_i;
      end else begin : g_always
         logic unused_en;
         assign unused_en = en_i;
         assign out_o     = in_i ^ mask_i;
      end
   endgenerate

endmodule

// File: rtl/fij_par_gen.sv
module fij_par_gen #(
   parameter int unsigned W   = 32,
   parameter bit          ODD = 1'b0
) (
   input  logic [W-1:0] data_i,
   input  logic         corrupt_i,
   output logic         par_o
);

   localparam logic SENSE = ODD;

   assign par_o = (^data_i) ^ SENSE ^ corrupt_i;

endmodule

// File: rtl/fij_valid_stretch.sv
module fij_valid_stretch #(
   parameter int unsigned TYPE_W    = 3,
   parameter int unsigned MBOX_CODE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              valid_i,
   input  logic [TYPE_W-1:0] type_i,
   output logic              valid_o
);

   localparam logic [TYPE_W-1:0] MBOX = MBOX_CODE[TYPE_W-1:0];

   logic prev_q;
   logic mbox_q;
   logic pkt_start;
   logic pkt_end;

   assign pkt_start = valid_i && !prev_q;
   assign pkt_end   = prev_q && !valid_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         mbox_q <= 1'b0;
      end else begin
         prev_q <= valid_i;
         if (pkt_start) begin
            mbox_q <= (type_i == MBOX);
         end
      end
   end

   assign valid_o = valid_i || (en_i && pkt_end && mbox_q);

endmodule

// File: rtl/fault_inj_ctl.sv
module fault_inj_ctl
   import fij_pkg::*;
#(
   parameter int unsigned DATA_W       = 64,
   parameter int unsigned RR_W         = 64,
   parameter int unsigned ECC_W        = 8,
   parameter int unsigned TYPE_W       = 3,
   parameter int unsigned MBOX_CODE    = 5,
   parameter int unsigned CSR_AW       = 8,
   parameter int unsigned REG_ADDR     = 64,
   parameter bit          CSR_PAR_ODD  = 1'b0,
   parameter bit          ECC_ON_VALID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_req_i,
   input  logic              csr_wr_i,
   input  logic [CSR_AW-1:0] csr_addr_i,
   input  logic [31:0]       csr_wdata_i,
   input  logic              csr_apar_i,
   output logic              csr_apar_o,
   output logic [31:0]       csr_rdata_o,
   output logic              csr_rdata_par_o,
   input  logic              dn_valid_i,
   input  logic [TYPE_W-1:0] dn_type_i,
   input  logic [DATA_W-1:0] dn_data_i,
   input  logic              dn_par_i,
   output logic              dn_valid_o,
   output logic [TYPE_W-1:0] dn_type_o,
   output logic [DATA_W-1:0] dn_data_o,
   output logic              dn_par_o,
   input  logic              rr_valid_i,
   input  logic [RR_W-1:0]   rr_data_i,
   input  logic [ECC_W-1:0]  rr_ecc_i,
   output logic              rr_valid_o,
   output logic [RR_W-1:0]   rr_data_o,
   output logic [ECC_W-1:0]  rr_ecc_o
);

   generate
      if (ECC_W < 1 || ECC_W > MASK_W) begin : g_bad_ecc_w
         initial $fatal(1, "ECC_W must be in 1..8");
      end
      if (TYPE_W < 1 || TYPE_W > 16) begin : g_bad_type_w
         initial $fatal(1, "TYPE_W must be in 1..16");
      end
      if (MBOX_CODE >= (1 << TYPE_W)) begin : g_bad_mbox
         initial $fatal(1, "MBOX_CODE does not fit TYPE_W");
      end
      if (CSR_AW < 1 || CSR_AW > 30 || REG_ADDR >= (1 << CSR_AW)) begin : g_bad_addr
         initial $fatal(1, "REG_ADDR does not fit CSR_AW");
      end
      if (DATA_W < 1 || RR_W < 1) begin : g_bad_data_w
         initial $fatal(1, "data widths must be non-zero");
      end
   endgenerate

   ctrl_t              ctrl;
   logic [ECC_W-1:0]   ecc_mask;
   logic               dn_par_en;
   logic               vseq_en;
   logic               apar_en;
   logic               dpar_en;

   fij_csr_regs #(
      .CSR_AW   (CSR_AW),
      .REG_ADDR (REG_ADDR)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (csr_req_i),
      .wr_i    (csr_wr_i),
      .addr_i  (csr_addr_i),
      .wdata_i (csr_wdata_i),
      .rdata_o (csr_rdata_o),
      .ctrl_o  (ctrl)
   );

   assign ecc_mask  = ctrl.ecc_mask[ECC_W-1:0];
   assign dn_par_en = ctrl.dn_par;
   assign vseq_en   = ctrl.vseq;
   assign apar_en   = ctrl.csr_apar;
   assign dpar_en   = ctrl.csr_dpar;

   generate
      if (ECC_W < MASK_W) begin : g_mask_trim
         logic unused_mask_hi;
         assign unused_mask_hi = ^ctrl.ecc_mask[MASK_W-1:ECC_W];
      end
   endgenerate

   // CSR side: address parity and read-data parity.
   fij_flip #(.W(1), .GATED(1'b1)) u_apar (
      .in_i   (csr_apar_i),
      .mask_i (1'b1),
      .en_i   (apar_en),
      .out_o  (csr_apar_o)
   );

   fij_par_gen #(.W(32), .ODD(CSR_PAR_ODD)) u_dpar (
      .data_i    (csr_rdata_o),
      .corrupt_i (dpar_en),
      .par_o     (csr_rdata_par_o)
   );

   // Downstream bus: parity flip and valid stretch.
   fij_flip #(.W(1), .GATED(1'b1)) u_dn_par (
      .in_i   (dn_par_i),
      .mask_i (1'b1),
      .en_i   (dn_par_en),
      .out_o  (dn_par_o)
   );

   fij_valid_stretch #(
      .TYPE_W    (TYPE_W),
      .MBOX_CODE (MBOX_CODE)
   ) u_stretch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (vseq_en),
      .valid_i (dn_valid_i),
      .type_i  (dn_type_i),
      .valid_o (dn_valid_o)
   );

   assign dn_type_o = dn_type_i;
   assign dn_data_o = dn_data_i;

   // Read return: per-check-bit flips.
   fij_flip #(.W(ECC_W), .GATED(ECC_ON_VALID)) u_ecc (
      .in_i   (rr_ecc_i),
      .mask_i (ecc_mask),
      .en_i   (rr_valid_i),
      .out_o  (rr_ecc_o)
   );

   assign rr_valid_o = rr_valid_i;
   assign rr_data_o  = rr_data_i;

endmodule

// File: rtl/fij_chk.sv
module fij_chk #(
   parameter int unsigned ECC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csr_req_i,
   input logic [31:0]      csr_rdata_o,
   input logic             csr_apar_i,
   input logic             csr_apar_o,
   input logic             dn_valid_i,
   input logic             dn_valid_o,
   input logic             dn_par_i,
   input logic             dn_par_o,
   input logic             rr_valid_i,
   input logic [ECC_W-1:0] rr_ecc_i,
   input logic [ECC_W-1:0] rr_ecc_o,
   input logic [ECC_W-1:0] ecc_mask,
   input logic             dn_par_en,
   input logic             vseq_en
);

   // R2: hidden and reserved positions never read back as one
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata_o[31:20] == '0) && (csr_rdata_o[15:8] == '0) && !csr_rdata_o[17]);

   // R4: flipped check bit count equals mask weight during read return
   p_ecc_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rr_valid_i |-> ($countones(rr_ecc_o ^ rr_ecc_i) == $countones(ecc_mask)));

   // R3: no check bit touched outside read return
   p_ecc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rr_valid_i |-> (rr_ecc_o == rr_ecc_i));

   // R5: downstream parity differs only while its flip is enabled
   p_dn_par_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_par_o != dn_par_i) |-> dn_par_en);

   // R8: forced address parity is gone the cycle after an access
   p_apar_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req_i && (csr_apar_o != csr_apar_i)) |=> (csr_apar_o == csr_apar_i));

   // R6: an extra valid cycle never lasts two cycles
   p_stretch_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid_o && !dn_valid_i) |=> !(dn_valid_o && !dn_valid_i));

   // R7: an extra valid cycle follows a packet end with stretching enabled
   p_stretch_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid_o && !dn_valid_i) |-> ($past(dn_valid_i) && vseq_en));

   // R10: input valid always reaches the output
   p_valid_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid_i |-> dn_valid_o);

endmodule

bind fault_inj_ctl fij_chk #(.ECC_W(ECC_W)) u_fij_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_req_i   (csr_req_i),
   .csr_rdata_o (csr_rdata_o),
   .csr_apar_i  (csr_apar_i),
   .csr_apar_o  (csr_apar_o),
   .dn_valid_i  (dn_valid_i),
   .dn_valid_o  (dn_valid_o),
   .dn_par_i    (dn_par_i),
   .dn_par_o    (dn_par_o),
   .rr_valid_i  (rr_valid_i),
   .rr_ecc_i    (rr_ecc_i),
   .rr_ecc_o    (rr_ecc_o),
   .ecc_mask    (ecc_mask),
   .dn_par_en   (dn_par_en),
   .vseq_en     (vseq_en)
);

// File: tb/fault_inj_ctl_tb_top.sv
module fault_inj_ctl_tb_top;

   localparam int unsigned DATA_W = 64;
   localparam int unsigned RR_W   = 64;
   localparam int unsigned ECC_W  = 8;
   localparam int unsigned TYPE_W = 3;
   localparam int unsigned MBOX   = 5;
   localparam int unsigned CSR_AW = 8;
   localparam logic [7:0]  RADDR  = 8'h40;
   localparam logic [7:0]  OADDR  = 8'h44;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              csr_req_i = 1'b0;
   logic              csr_wr_i = 1'b0;
   logic [CSR_AW-1:0] csr_addr_i = '0;
   logic [31:0]       csr_wdata_i = '0;
   logic              csr_apar_i = 1'b0;
   logic              csr_apar_o;
   logic [31:0]       csr_rdata_o;
   logic              csr_rdata_par_o;
   logic              dn_valid_i = 1'b0;
   logic [TYPE_W-1:0] dn_type_i = '0;
   logic [DATA_W-1:0] dn_data_i = '0;
   logic              dn_par_i = 1'b0;
   logic              dn_valid_o;
   logic [TYPE_W-1:0] dn_type_o;
   logic [DATA_W-1:0] dn_data_o;
   logic              dn_par_o;
   logic              rr_valid_i = 1'b0;
   logic [RR_W-1:0]   rr_data_i = '0;
   logic [ECC_W-1:0]  rr_ecc_i = '0;
   logic              rr_valid_o;
   logic [RR_W-1:0]   rr_data_o;
   logic [ECC_W-1:0]  rr_ecc_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fault_inj_ctl dut_i (
      .clk(clk), .rst_n(rst_n),
      .csr_req_i(csr_req_i), .csr_wr_i(csr_wr_i), .csr_addr_i(csr_addr_i),
      .csr_wdata_i(csr_wdata_i), .csr_apar_i(csr_apar_i), .csr_apar_o(csr_apar_o),
      .csr_rdata_o(csr_rdata_o), .csr_rdata_par_o(csr_rdata_par_o),
      .dn_valid_i(dn_valid_i), .dn_type_i(dn_type_i), .dn_data_i(dn_data_i),
      .dn_par_i(dn_par_i), .dn_valid_o(dn_valid_o), .dn_type_o(dn_type_o),
      .dn_data_o(dn_data_o), .dn_par_o(dn_par_o),
      .rr_valid_i(rr_valid_i), .rr_data_i(rr_data_i), .rr_ecc_i(rr_ecc_i),
      .rr_valid_o(rr_valid_o), .rr_data_o(rr_data_o), .rr_ecc_o(rr_ecc_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_req_i = 1'b1; csr_wr_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
      @(negedge clk);
      csr_req_i = 1'b0; csr_wr_i = 1'b0; csr_wdata_i = '0;
   endtask

   task automatic csr_read(input logic [7:0] a, output logic [31:0] d, output logic p);
      @(negedge clk);
      csr_req_i = 1'b1; csr_wr_i = 1'b0; csr_addr_i = a;
      #1;
      d = csr_rdata_o; p = csr_rdata_par_o;
      @(negedge clk);
      csr_req_i = 1'b0;
   endtask

   // One packet of len cycles, then the two cycles after it.
   task automatic send_pkt(input int t, input int len, input bit stretch_on);
      bit ext;
      ext = stretch_on && (t == MBOX);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         dn_valid_i = 1'b1;
         dn_type_i  = (i == 0) ? t[TYPE_W-1:0] : ~t[TYPE_W-1:0];
         #1 chk(dn_valid_o == 1'b1, "R10 valid in packet", dn_valid_o, 1);
      end
      @(negedge clk);
      dn_valid_i = 1'b0; dn_type_i = '0;
      #1;
      if (ext) chk(dn_valid_o == 1'b1, "R6 extra valid", dn_valid_o, 1);
      else     chk(dn_valid_o == 1'b0, "R7 no extra valid", dn_valid_o, 0);
      @(negedge clk);
      #1 chk(dn_valid_o == 1'b0, "R6 one extra only", dn_valid_o, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      logic        rp;
      logic [7:0]  pat;
      logic [7:0]  expe;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      csr_read(RADDR, rd, rp);
      chk(rd == 32'h0, "R1 reset readback", rd, 0);
      chk(rp == 1'b0, "R1 reset read parity", rp, 0);
      @(negedge clk);
      dn_data_i = 64'hDEAD_BEEF_0123_4567; dn_par_i = 1'b1; dn_type_i = 3'd6;
      rr_valid_i = 1'b1; rr_data_i = 64'h0F0F_1234_5678_9ABC; rr_ecc_i = 8'h5A;
      csr_apar_i = 1'b1;
      #1;
      chk(dn_data_o == dn_data_i && dn_type_o == dn_type_i, "R10 dn data/type pass", dn_data_o, dn_data_i);
      chk(dn_par_o == 1'b1, "R1 dn parity pass", dn_par_o, 1);
      chk(rr_ecc_o == 8'h5A && rr_data_o == rr_data_i && rr_valid_o, "R1 ecc pass", rr_ecc_o, 8'h5A);
      chk(csr_apar_o == 1'b1, "R10 apar pass", csr_apar_o, 1);
      rr_valid_i = 1'b0; csr_apar_i = 1'b0;

      // R2 readback of all writable bits
      csr_write(RADDR, 32'hFFFF_FFFF);
      #1 chk(csr_apar_o == 1'b1, "R8 apar forced after write", csr_apar_o, 1);
      csr_read(RADDR, rd, rp);
      chk(rd == 32'h000D_00FF, "R2 readback all ones", rd, 32'h000D_00FF);
      chk(rp == ~(^rd), "R9 forced read parity", rp, ~(^rd));
      #1 chk(csr_apar_o == 1'b0, "R8 apar cleared by read", csr_apar_o, 0);

      // R11 other address ignored
      csr_write(OADDR, 32'h0000_0000);
      csr_read(OADDR, rd, rp);
      chk(rd == 32'h0, "R11 other address reads zero", rd, 0);
      csr_read(RADDR, rd, rp);
      chk(rd == 32'h000D_00FF, "R11 word kept after foreign write", rd, 32'h000D_00FF);

      // R9 parity with bit 16 clear and set
      csr_write(RADDR, 32'h0000_0007);
      csr_read(RADDR, rd, rp);
      chk(rd == 32'h7 && rp == 1'b1, "R9 normal read parity", {rd, 31'b0, rp}, {32'h7, 32'h1});
      csr_write(RADDR, 32'h0001_0003);
      csr_read(RADDR, rd, rp);
      chk(rd == 32'h0001_0003 && rp == 1'b0, "R9 inverted read parity", {rd, 31'b0, rp}, {32'h0001_0003, 32'h0});

      // R8 self-clearing address parity
      csr_write(RADDR, 32'h0002_0000);
      for (int v = 0; v < 2; v++) begin
         @(negedge clk);
         csr_apar_i = v[0];
         #1 chk(csr_apar_o == ~v[0], "R8 apar inverted while idle", csr_apar_o, ~v[0]);
      end
      @(negedge clk);
      csr_req_i = 1'b1; csr_wr_i = 1'b0; csr_addr_i = OADDR; csr_apar_i = 1'b0;
      #1 chk(csr_apar_o == 1'b1, "R8 apar inverted during access", csr_apar_o, 1);
      @(negedge clk);
      csr_req_i = 1'b0;
      #1 chk(csr_apar_o == 1'b0, "R8 apar clear after access", csr_apar_o, 0);
      csr_read(RADDR, rd, rp);
      chk(rd == 32'h0, "R2 bit 17 reads zero", rd, 0);
      csr_write(OADDR, 32'h0002_0000);
      #1 chk(csr_apar_o == 1'b0, "R11 foreign write does not force", csr_apar_o, 0);

      // R5 downstream parity flip
      csr_write(RADDR, 32'h0004_0000);
      for (int v = 0; v < 2; v++) begin
         @(negedge clk);
         dn_par_i = v[0];
         #1 chk(dn_par_o == ~v[0], "R5 dn parity inverted", dn_par_o, ~v[0]);
      end
      csr_write(RADDR, 32'h0);
      #1 chk(dn_par_o == dn_par_i, "R5 dn parity restored", dn_par_o, dn_par_i);

      // R3/R4 sweep every mask over several check-bit patterns
      for (int m = 0; m < 256; m++) begin
         csr_write(RADDR, m);
         for (int p = 0; p < 3; p++) begin
            pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hA5 : 8'hFF;
            expe = pat ^ m[7:0];
            @(negedge clk);
            rr_valid_i = 1'b1; rr_ecc_i = pat;
            #1;
            chk(rr_ecc_o == expe, "R3 ecc flip", rr_ecc_o, expe);
            chk($countones(rr_ecc_o ^ pat) == $countones(m[7:0]), "R4 error weight",
                $countones(rr_ecc_o ^ pat), $countones(m[7:0]));
            rr_valid_i = 1'b0;
            #1 chk(rr_ecc_o == pat, "R3 no flip without valid", rr_ecc_o, pat);
         end
      end

      // R6/R7 valid stretch over all types and lengths
      csr_write(RADDR, 32'h0008_0000);
      for (int t = 0; t < 8; t++)
         for (int len = 1; len <= 3; len++)
            send_pkt(t, len, 1'b1);
      csr_write(RADDR, 32'h0);
      send_pkt(MBOX, 2, 1'b0);
      send_pkt(MBOX, 1, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule